// File: doc/BRIEF.md
# Global signal-group pad multiplexer

This block sits between a row of shared package pads and the chip's internal logic. One small group-select register picks one of seven signal groups. That single setting changes the job of every shared pad in the same clock edge. No pad has a function select of its own.

For each pad, every group names either a fixed internal function or a general-purpose line. A fixed function's signals come straight from, or go straight to, an internal block. A general-purpose line is an intermediate signal that a later multiplexer stage handles. In the default group (0), the pads reach fixed functions only and no general-purpose line touches a pad. Group 0 is the boot routing, used for example to put a CPU debug port on the pads without any configuration. The other groups either move the pads to other fixed functions or hand them to rotated ranges of general-purpose lines. Software writes the group number through a one-cycle write strobe and can read the active group back at any time.

Top module: `pad_group_mux`

## Requirements
- R1: After reset the active group is 0, and `rd_data_o` reads 0.
- R2: When `wr_en_i` is high with `wr_data_i` in 0..6, the group is captured on that rising clock edge. `rd_data_o` and the routing of every pad change together at that edge and not before it.
- R3: A write of value 7 is ignored. `rd_data_o` and the pad routing keep their previous values.
- R4: Groups 0, 2 and 3 use fixed slots 0, 1 and 2 respectively. In fixed slot s, pad p drives `pad_o[p]` from `fix_out_i[s*NUM_PADS+p]` and `pad_oe_o[p]` from `fix_oe_i[s*NUM_PADS+p]`.
- R5: A fixed function with (p+s) mod 3 == 2 is input-only. For that function the pad drives `pad_oe_o[p]=0` and `pad_o[p]=0`, whatever `fix_out_i` and `fix_oe_i` hold.
- R6: Groups 1, 4, 5 and 6 route pad p to general-purpose line (p+k) mod NUM_LINES, where k is 0 for group 1 and k is the group number for groups 4 to 6. In these groups `pad_o[p]` comes from `gpl_out_i` of that line and `pad_oe_o[p]` comes from `gpl_oe_i` of that line.
- R7: In a fixed group, `fix_in_o[s*NUM_PADS+p]` equals `pad_i[p]` for the active slot s. Every other bit of `fix_in_o` is 0, and in the general-purpose-line groups the whole of `fix_in_o` is 0.
- R8: In a general-purpose-line group, the line a pad maps to shows `pad_i` of that pad on `gpl_in_o`. Lines that no pad maps to read 0.
- R9: In group 0, `gpl_in_o` is all zero and the pad outputs do not depend on `gpl_out_i` or `gpl_oe_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Group-select write strobe |
| wr_data_i | input | 3 | Group number to write |
| rd_data_o | output | 3 | Active group number |
| pad_i | input | NUM_PADS | Pad input levels |
| pad_o | output | NUM_PADS | Pad output levels |
| pad_oe_o | output | NUM_PADS | Pad output enables |
| fix_out_i | input | 3*NUM_PADS | Fixed-function outputs, slot-major |
| fix_oe_i | input | 3*NUM_PADS | Fixed-function output enables, slot-major |
| fix_in_o | output | 3*NUM_PADS | Pad inputs delivered to fixed functions |
| gpl_out_i | input | NUM_LINES | General-purpose line outputs |
| gpl_oe_i | input | NUM_LINES | General-purpose line output enables |
| gpl_in_o | output | NUM_LINES | Pad inputs delivered to general-purpose lines |

## Verification
The only state is the stored group, so any corruption of it changes every pad's routing at once. It also changes the read-back value in the same cycle. A one-hot vector with a lost or doubled bit would show up as OR-ed routing or as dead pads on the very next combinational sample. Wrong write qualification shows up one edge after the write, through the read-back value or a pad that switches early or late. The bench drives distinct patterns on every fixed-function and line input in every group. This means that a wrong slot, rotation or input-only mask shows as a specific wrong pad bit.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  localparam int GRP_W    = 3;
  localparam int NUM_GRP  = 7;
  localparam int NUM_SLOT = 3;

  function automatic bit is_gpl_grp(input int g);
    return (g == 1) || (g >= 4);
  endfunction

  function automatic int fix_slot(input int g);
    return (g == 0) ? 0 : (g == 2) ? 1 : 2;
  endfunction

  function automatic int slot_grp(input int s);
    return (s == 0) ? 0 : (s == 1) ? 2 : 3;
  endfunction

  function automatic int gpl_off(input int g);
    return (g == 1) ? 0 : g;
  endfunction

  function automatic bit in_only(input int s, input int p);
    return ((p + s) % 3) == 2;
  endfunction
endpackage

// File: rtl/pgm_sel_reg.sv
module pgm_sel_reg
  import pgm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [GRP_W-1:0] wr_data_i,
  output logic [NUM_GRP-1:0] grp_oh_o,
  output logic [GRP_W-1:0] grp_o
);
  logic [NUM_GRP-1:0] grp_oh_q;
  logic               wr_ok;

  assign wr_ok = wr_en_i && (int'(wr_data_i) < NUM_GRP);

  // one-hot state: each pad mux is a single AND-OR level with no decoder
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    grp_oh_q <= NUM_GRP'(1);
    else if (wr_ok) grp_oh_q <= NUM_GRP'(1) << wr_data_i;
  end

  always_comb begin
    grp_o = '0;
    for (int g = 0; g < NUM_GRP; g++)
      if (grp_oh_q[g]) grp_o = grp_o | GRP_W'(g);
  end

  assign grp_oh_o = grp_oh_q;
endmodule

// File: rtl/pgm_onehot_mux.sv
module pgm_onehot_mux #(
  parameter int N = 7
) (
  input  logic [N-1:0] sel_i,
  input  logic [N-1:0] data_i,
  output logic         y_o
);
  assign y_o = |(sel_i & data_i);
endmodule

// File: rtl/pgm_in_gather.sv
module pgm_in_gather
  import pgm_pkg::*;
#(
  parameter int NUM_PADS  = 8,
  parameter int NUM_LINES = 16,
  localparam int NUM_FIX  = NUM_SLOT * NUM_PADS
) (
  input  logic [NUM_GRP-1:0]   grp_oh_i,
  input  logic [NUM_PADS-1:0]  pad_i,
  output logic [NUM_FIX-1:0]   fix_in_o,
  output logic [NUM_LINES-1:0] gpl_in_o
);
  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
      assign fix_in_o[s*NUM_PADS+p] = pad_i[p] & grp_oh_i[slot_grp(s)];
    end
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic [NUM_GRP-1:0] term;
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      localparam int SRC = (l - (gpl_off(g) % NUM_LINES) + NUM_LINES) % NUM_LINES;
      if (is_gpl_grp(g) && (SRC < NUM_PADS)) begin : g_hit
        assign term[g] = pad_i[SRC] & grp_oh_i[g];
      end else begin : g_miss
        assign term[g] = 1'b0;
      end
    end
    assign gpl_in_o[l] = |term;
  end
endmodule

// File: rtl/pad_group_mux.sv
module pad_group_mux
  import pgm_pkg::*;
#(
  parameter int NUM_PADS  = 8,
  parameter int NUM_LINES = 16,
  localparam int NUM_FIX  = NUM_SLOT * NUM_PADS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [GRP_W-1:0]     wr_data_i,
  output logic [GRP_W-1:0]     rd_data_o,
  input  logic [NUM_PADS-1:0]  pad_i,
  output logic [NUM_PADS-1:0]  pad_o,
  output logic [NUM_PADS-1:0]  pad_oe_o,
  input  logic [NUM_FIX-1:0]   fix_out_i,
  input  logic [NUM_FIX-1:0]   fix_oe_i,
  output logic [NUM_FIX-1:0]   fix_in_o,
  input  logic [NUM_LINES-1:0] gpl_out_i,
  input  logic [NUM_LINES-1:0] gpl_oe_i,
  output logic [NUM_LINES-1:0] gpl_in_o
);
  logic [NUM_GRP-1:0] grp_oh;
  logic               unused_src;

  // input-only slots and unmapped lines leave some source bits unread
  assign unused_src = ^{fix_out_i, fix_oe_i, gpl_out_i, gpl_oe_i};

  pgm_sel_reg u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .grp_oh_o  (grp_oh),
    .grp_o     (rd_data_o)
  );

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    logic [NUM_GRP-1:0] src_o, src_oe;
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      if (is_gpl_grp(g)) begin : g_line
        localparam int LN = (p + gpl_off(g)) % NUM_LINES;
        assign src_o[g]  = gpl_out_i[LN];
        assign src_oe[g] = gpl_oe_i[LN];
      end else if (in_only(fix_slot(g), p)) begin : g_inonly
        assign src_o[g]  = 1'b0;
        assign src_oe[g] = 1'b0;
      end else begin : g_fix
        localparam int FI = fix_slot(g) * NUM_PADS + p;
        assign src_o[g]  = fix_out_i[FI];
        assign src_oe[g] = fix_oe_i[FI];
      end
    end

    pgm_onehot_mux #(.N(NUM_GRP)) u_mux_o (
      .sel_i (grp_oh), .data_i (src_o),  .y_o (pad_o[p])
    );
    pgm_onehot_mux #(.N(NUM_GRP)) u_mux_oe (
      .sel_i (grp_oh), .data_i (src_oe), .y_o (pad_oe_o[p])
    );
  end

  pgm_in_gather #(.NUM_PADS(NUM_PADS), .NUM_LINES(NUM_LINES)) u_gather (
    .grp_oh_i (grp_oh),
    .pad_i    (pad_i),
    .fix_in_o (fix_in_o),
    .gpl_in_o (gpl_in_o)
  );
endmodule

// File: rtl/pgm_chk.sv
module pgm_chk
  import pgm_pkg::*;
#(
  parameter int NUM_PADS  = 8,
  parameter int NUM_LINES = 16,
  localparam int NUM_FIX  = NUM_SLOT * NUM_PADS
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_en_i,
  input logic [GRP_W-1:0]     wr_data_i,
  input logic [GRP_W-1:0]     rd_data_o,
  input logic [NUM_PADS-1:0]  pad_o,
  input logic [NUM_PADS-1:0]  pad_oe_o,
  input logic [NUM_FIX-1:0]   fix_in_o,
  input logic [NUM_LINES-1:0] gpl_in_o
);
  function automatic logic [NUM_PADS-1:0] ionly_mask(input logic [GRP_W-1:0] g);
    ionly_mask = '0;
    if (!is_gpl_grp(int'(g)))
      for (int p = 0; p < NUM_PADS; p++)
        ionly_mask[p] = in_only(fix_slot(int'(g)), p);
  endfunction

  // R1
  reset_grp_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> rd_data_o == '0);

  // R2
  wr_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i != 3'd7 |=> rd_data_o == $past(wr_data_i));

  // R3
  wr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i == 3'd7 |=> $stable(rd_data_o));

  // R3
  grp_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o != 3'd7);

  // R5
  in_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o | pad_o) & ionly_mask(rd_data_o)) == '0);

  // R7
  fix_in_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_gpl_grp(int'(rd_data_o)) |-> fix_in_o == '0);

  // R9
  g0_no_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o == '0 |-> gpl_in_o == '0);
endmodule

bind pad_group_mux pgm_chk #(.NUM_PADS(NUM_PADS), .NUM_LINES(NUM_LINES)) u_chk (.*);

// File: tb/pad_group_mux_tb.sv
module pad_group_mux_tb;
  localparam int NP = 8;
  localparam int NL = 16;
  localparam int NF = 3 * NP;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_data = '0;
  logic [2:0]    rd_data;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe;
  logic [NF-1:0] fix_out = '0, fix_oe = '0, fix_in;
  logic [NL-1:0] gpl_out = '0, gpl_oe = '0, gpl_in;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  pad_group_mux #(.NUM_PADS(NP), .NUM_LINES(NL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .pad_i(pad_in), .pad_o(pad_out), .pad_oe_o(pad_oe),
    .fix_out_i(fix_out), .fix_oe_i(fix_oe), .fix_in_o(fix_in),
    .gpl_out_i(gpl_out), .gpl_oe_i(gpl_oe), .gpl_in_o(gpl_in)
  );

  function automatic bit line_grp(int g);
    return g == 1 || g >= 4;
  endfunction
  function automatic int slot_of(int g);
    return g == 0 ? 0 : g == 2 ? 1 : 2;
  endfunction
  function automatic int off_of(int g);
    return g == 1 ? 0 : g;
  endfunction

  function automatic logic [NP-1:0] e_pad(int g, bit want_oe);
    logic [NP-1:0] v = '0;
    for (int p = 0; p < NP; p++) begin
      if (line_grp(g)) begin
        int l = (p + off_of(g)) % NL;
        v[p] = want_oe ? gpl_oe[l] : gpl_out[l];
      end else if (((p + slot_of(g)) % 3) != 2) begin
        v[p] = want_oe ? fix_oe[slot_of(g)*NP+p] : fix_out[slot_of(g)*NP+p];
      end
    end
    return v;
  endfunction

  function automatic logic [NF-1:0] e_fix_in(int g);
    logic [NF-1:0] v = '0;
    if (!line_grp(g))
      for (int p = 0; p < NP; p++) v[slot_of(g)*NP+p] = pad_in[p];
    return v;
  endfunction

  function automatic logic [NL-1:0] e_gpl_in(int g);
    logic [NL-1:0] v = '0;
    if (line_grp(g))
      for (int p = 0; p < NP; p++) v[(p + off_of(g)) % NL] = pad_in[p];
    return v;
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic write_grp(logic [2:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic shuffle();
    fix_out = NF'({$urandom, $urandom});
    fix_oe  = NF'({$urandom, $urandom});
    gpl_out = NL'($urandom);
    gpl_oe  = NL'($urandom);
    pad_in  = NP'($urandom);
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk("R1", "rd_data", 64'(rd_data), 64'd0);
    chk("R9", "gpl_in at reset", 64'(gpl_in), 64'd0);
  endtask

  task automatic t_fixed();
    int grps[3] = '{0, 2, 3};
    foreach (grps[i]) begin
      write_grp(3'(grps[i]));
      chk("R2", "rd_data", 64'(rd_data), 64'(grps[i]));
      for (int k = 0; k < 3; k++) begin
        shuffle();
        chk("R4", "pad_o", 64'(pad_out), 64'(e_pad(grps[i], 0)));
        chk("R4", "pad_oe", 64'(pad_oe), 64'(e_pad(grps[i], 1)));
        chk("R7", "fix_in", 64'(fix_in), 64'(e_fix_in(grps[i])));
      end
      fix_out = '1; fix_oe = '1; #1;
      chk("R5", "pad_oe all-ones src", 64'(pad_oe), 64'(e_pad(grps[i], 1)));
      chk("R5", "pad_o all-ones src", 64'(pad_out), 64'(e_pad(grps[i], 0)));
    end
  endtask

  task automatic t_group0_isolation();
    logic [NP-1:0] o0, oe0;
    write_grp(3'd0);
    shuffle();
    o0 = pad_out; oe0 = pad_oe;
    gpl_out = ~gpl_out; gpl_oe = ~gpl_oe; pad_in = '1; #1;
    chk("R9", "pad_o vs line change", 64'(pad_out), 64'(o0));
    chk("R9", "pad_oe vs line change", 64'(pad_oe), 64'(oe0));
    chk("R9", "gpl_in", 64'(gpl_in), 64'd0);
  endtask

  task automatic t_lines();
    int grps[4] = '{1, 4, 5, 6};
    foreach (grps[i]) begin
      write_grp(3'(grps[i]));
      chk("R2", "rd_data", 64'(rd_data), 64'(grps[i]));
      for (int k = 0; k < 3; k++) begin
        shuffle();
        chk("R6", "pad_o", 64'(pad_out), 64'(e_pad(grps[i], 0)));
        chk("R6", "pad_oe", 64'(pad_oe), 64'(e_pad(grps[i], 1)));
        chk("R8", "gpl_in", 64'(gpl_in), 64'(e_gpl_in(grps[i])));
        chk("R7", "fix_in idle", 64'(fix_in), 64'd0);
      end
      pad_in = '1; #1;
      chk("R8", "gpl_in all pads high", 64'(gpl_in), 64'(e_gpl_in(grps[i])));
    end
  endtask

  task automatic t_invalid();
    logic [NP-1:0] o_prev;
    write_grp(3'd5);
    shuffle();
    o_prev = pad_out;
    write_grp(3'd7);
    chk("R3", "rd_data after 7", 64'(rd_data), 64'd5);
    chk("R3", "pad_o after 7", 64'(pad_out), 64'(o_prev));
    chk("R3", "gpl_in after 7", 64'(gpl_in), 64'(e_gpl_in(5)));
  endtask

  task automatic t_edge();
    write_grp(3'd2);
    shuffle();
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = 3'd6;
    #1;
    chk("R2", "rd before edge", 64'(rd_data), 64'd2);
    chk("R2", "pad_o before edge", 64'(pad_out), 64'(e_pad(2, 0)));
    @(posedge clk);
    #1;
    chk("R2", "rd after edge", 64'(rd_data), 64'd6);
    chk("R2", "pad_o after edge", 64'(pad_out), 64'(e_pad(6, 0)));
    chk("R2", "pad_oe after edge", 64'(pad_oe), 64'(e_pad(6, 1)));
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fixed();
    t_group0_isolation();
    t_lines();
    t_invalid();
    t_edge();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule